// File: doc/BRIEF.md
# Four-Channel DAC Refresh Serial Master

This block is the write side of a display path that shows four state words on two external dual-channel 12-bit converters. One send strobe hands it four signed 16-bit fractional words, all captured in that clock cycle. The block turns each word into an unsigned 12-bit code and sends four 16-bit serial frames on a shared clock and data line. The first converter receives channels 0 and 1 and the second receives channels 2 and 3. Each converter has its own active-low select.

When the fourth frame is done, the block drives a shared active-low load line low for a few clocks, so all four analog outputs move together. It then reports completion with a one-cycle done pulse. The serial clock is a divided copy of the system clock. A `DIV_HALF` parameter sets how many system clocks each half of a serial clock period lasts.

Top module: `dac_pair_spi_tx`

## Requirements
- R1: After reset, both selects and the load line are high, the serial clock is low, and busy and done are low.
- R2: Each frame is 16 bits, most significant first, in SPI mode 0. The serial clock rests low, data is stable at each rising edge and changes only at falling edges, and each select window holds exactly 16 rising edges.
- R3: Frames go out in input order. Words 0 and 1 go under select A with channel bit 0 then 1. Words 2 and 3 go under select B with channel bit 0 then 1.
- R4: Frame bit 15 is the channel bit. Bit 14 is 0, bit 13 is 1 and bit 12 is 1.
- R5: Frame bits 11:0 hold the inverted sign bit followed by input bits 14:4. So 0x8000 becomes 0, 0x7FFF becomes 4095, 0x0000 becomes 2048 and 0xFFFF becomes 2047.
- R6: At most one select is low at a time. Each select falls DIV_HALF system clocks before its first rising edge and rises DIV_HALF system clocks after its last falling edge.
- R7: After the fourth frame, the load line goes low for LDAC_CYC clocks (at least 2) while both selects are high. There is exactly one such pulse per accepted send.
- R8: Busy is high from the clock after an accepted send. Done is high for exactly one clock, starting one clock after the load line returns high, and busy is low during that clock.
- R9: A send strobe that arrives while busy is high is ignored. No restart occurs and no extra frames or load pulses appear.
- R10: The four words are captured in the clock where the send is accepted. Later input changes do not alter the frames in progress.
- R11: A send strobe that arrives in the done clock is accepted, and a full new sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Start strobe; samples the four words |
| st0_i | input | 16 | State word 0, signed fraction |
| st1_i | input | 16 | State word 1, signed fraction |
| st2_i | input | 16 | State word 2, signed fraction |
| st3_i | input | 16 | State word 3, signed fraction |
| sck_o | output | 1 | Serial clock, mode 0 |
| sdo_o | output | 1 | Serial data, MSB first |
| cs_a_n_o | output | 1 | Select of converter A, active low |
| cs_b_n_o | output | 1 | Select of converter B, active low |
| ldac_n_o | output | 1 | Shared load strobe, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can meet in one clock. First, a new send strobe can coincide with the done pulse of the previous sequence. Second, a send strobe can arrive while frames are still being shifted out. The bench provokes the first by raising send in the very cycle it sees done. It expects eight decoded frames and two load pulses, with the second set of words carrying the new codes. It provokes the second by pulsing send with different words in the middle of a frame. A serial-side monitor must then see only the original four frames and a single load pulse.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_XFER,
        PH_LDAC,
        PH_GAP,
        PH_DONE
    } dps_phase_e;

endpackage

// File: rtl/dps_half_tick.sv
module dps_half_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == CNT_W'(DIV_HALF - 1));
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < DIV_HALF);  // R6

endmodule

// File: rtl/dps_code_map.sv
module dps_code_map #(
    parameter int IN_W   = 16,
    parameter int CODE_W = 12
) (
    input  logic [IN_W-1:0]   val_i,
    output logic [CODE_W-1:0] code_o
);
    // Offset-binary: flip the sign, keep the top CODE_W bits.
    assign code_o = {~val_i[IN_W-1], val_i[IN_W-2 -: CODE_W-1]};
endmodule

// File: rtl/dps_word_build.sv
module dps_word_build #(
    parameter int CODE_W = 12,
    localparam int WORD_W = CODE_W + 4
) (
    input  logic              ch_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [WORD_W-1:0] word_o
);
    // channel, unbuffered reference, unity gain, output active, code
    assign word_o = {ch_i, 1'b0, 1'b1, 1'b1, code_i};
endmodule

// File: rtl/dac_pair_spi_tx.sv
module dac_pair_spi_tx
    import dps_pkg::*;
#(
    parameter int IN_W     = 16,
    parameter int CODE_W   = 12,
    parameter int DIV_HALF = 2,
    parameter int LDAC_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            send_i,
    input  logic [IN_W-1:0] st0_i,
    input  logic [IN_W-1:0] st1_i,
    input  logic [IN_W-1:0] st2_i,
    input  logic [IN_W-1:0] st3_i,
    output logic            sck_o,
    output logic            sdo_o,
    output logic            cs_a_n_o,
    output logic            cs_b_n_o,
    output logic            ldac_n_o,
    output logic            busy_o,
    output logic            done_o
);
    localparam int WORD_W    = CODE_W + 4;
    localparam int N_CH      = 4;
    localparam int FR_W      = $clog2(N_CH);
    localparam int HALF_LAST = 2 * WORD_W + 1;
    localparam int HALF_W    = $clog2(HALF_LAST + 1);
    localparam int LDAC_W    = $clog2(LDAC_CYC + 1);

    typedef struct packed {
        dps_phase_e               phase;
        logic [FR_W-1:0]          frame;
        logic [HALF_W-1:0]        half;
        logic [WORD_W-1:0]        sr;
        logic [N_CH*CODE_W-1:0]   codes;
        logic                     sck;
        logic                     cs_a_n;
        logic                     cs_b_n;
        logic                     ldac_n;
        logic [LDAC_W-1:0]        lcnt;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic [IN_W-1:0]        st_in [N_CH];
    logic [N_CH*CODE_W-1:0] codes_now;
    logic [WORD_W-1:0]      word_first, word_next;
    logic [FR_W-1:0]        nf;
    logic                   tick;

    assign st_in[0] = st0_i;
    assign st_in[1] = st1_i;
    assign st_in[2] = st2_i;
    assign st_in[3] = st3_i;

    for (genvar g = 0; g < N_CH; g++) begin : g_map
        dps_code_map #(.IN_W(IN_W), .CODE_W(CODE_W)) u_map (
            .val_i  (st_in[g]),
            .code_o (codes_now[g*CODE_W +: CODE_W])
        );
    end

    assign nf = st_q.frame + 1'b1;

    dps_word_build #(.CODE_W(CODE_W)) u_word_first (
        .ch_i   (1'b0),
        .code_i (codes_now[CODE_W-1:0]),
        .word_o (word_first)
    );

    dps_word_build #(.CODE_W(CODE_W)) u_word_next (
        .ch_i   (nf[0]),
        .code_i (st_q.codes[32'(nf)*CODE_W +: CODE_W]),
        .word_o (word_next)
    );

    dps_half_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.phase == PH_XFER),
        .tick_o (tick)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE, PH_DONE: begin
                st_d.phase = PH_IDLE;
                if (send_i) begin
                    st_d.phase  = PH_XFER;
                    st_d.frame  = '0;
                    st_d.half   = '0;
                    st_d.sr     = word_first;
                    st_d.codes  = codes_now;
                    st_d.sck    = 1'b0;
                    st_d.cs_a_n = 1'b0;
                    st_d.cs_b_n = 1'b1;
                end
            end
            PH_XFER: begin
                if (tick) begin
                    if (st_q.half == HALF_W'(HALF_LAST)) begin
                        if (st_q.frame == FR_W'(N_CH - 1)) begin
                            st_d.phase  = PH_LDAC;
                            st_d.ldac_n = 1'b0;
                            st_d.lcnt   = '0;
                        end else begin
                            st_d.frame  = nf;
                            st_d.half   = '0;
                            st_d.sr     = word_next;
                            st_d.cs_a_n = nf[FR_W-1];
                            st_d.cs_b_n = ~nf[FR_W-1];
                        end
                    end else begin
                        st_d.half = st_q.half + 1'b1;
                        if (st_q.half == HALF_W'(HALF_LAST - 1)) begin
                            st_d.cs_a_n = 1'b1;
                            st_d.cs_b_n = 1'b1;
                            st_d.sck    = 1'b0;
                        end else if (!st_q.half[0]) begin
                            st_d.sck = 1'b1;
                        end else begin
                            st_d.sck = 1'b0;
                            st_d.sr  = {st_q.sr[WORD_W-2:0], 1'b0};
                        end
                    end
                end
            end
            PH_LDAC: begin
                if (st_q.lcnt == LDAC_W'(LDAC_CYC - 1)) begin
                    st_d.ldac_n = 1'b1;
                    st_d.phase  = PH_GAP;
                end else begin
                    st_d.lcnt = st_q.lcnt + 1'b1;
                end
            end
            PH_GAP:  st_d.phase = PH_DONE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.phase  <= PH_IDLE;
            st_q.cs_a_n <= 1'b1;
            st_q.cs_b_n <= 1'b1;
            st_q.ldac_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_o    = st_q.sck;
    assign sdo_o    = st_q.sr[WORD_W-1];
    assign cs_a_n_o = st_q.cs_a_n;
    assign cs_b_n_o = st_q.cs_b_n;
    assign ldac_n_o = st_q.ldac_n;
    assign busy_o   = (st_q.phase == PH_XFER) || (st_q.phase == PH_LDAC) ||
                      (st_q.phase == PH_GAP);
    assign done_o   = (st_q.phase == PH_DONE);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_a_n_o || cs_b_n_o);  // R6

    AST_SCK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a_n_o && cs_b_n_o) |-> !sck_o);  // R2

    AST_SDO_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cs_a_n_o && cs_b_n_o) && !$past(cs_a_n_o && cs_b_n_o) && !$fell(sck_o))
        |-> $stable(sdo_o));  // R2

    AST_LOAD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n_o |-> (cs_a_n_o && cs_b_n_o));  // R7

    AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldac_n_o) |-> !$past(ldac_n_o, 2));  // R7

    AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ldac_n_o && !busy_o && !$past(ldac_n_o, 2)));  // R8

    AST_SEND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && send_i) |=> ($stable(st_q.codes) && busy_o));  // R9

endmodule

// File: tb/dac_pair_spi_tx_bench.sv
`timescale 1ns/1ps
module dac_pair_spi_tx_bench;
    localparam int DIV_HALF = 2;
    localparam int LDAC_CYC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        send = 1'b0;
    logic [15:0] st0 = '0, st1 = '0, st2 = '0, st3 = '0;
    logic        sck, sdo, cs_a_n, cs_b_n, ldac_n, busy, done;

    always #2.5 clk = ~clk;

    dac_pair_spi_tx #(.DIV_HALF(DIV_HALF), .LDAC_CYC(LDAC_CYC)) u_dac_pair_spi_tx (
        .clk(clk), .rst_n(rst_n), .send_i(send),
        .st0_i(st0), .st1_i(st1), .st2_i(st2), .st3_i(st3),
        .sck_o(sck), .sdo_o(sdo), .cs_a_n_o(cs_a_n), .cs_b_n_o(cs_b_n),
        .ldac_n_o(ldac_n), .busy_o(busy), .done_o(done)
    );

    int n_chk = 0;
    int n_fail = 0;

    // ---------------- serial-side monitor ----------------
    int          cyc = 0;
    logic        p_sck = 1'b0, p_csa = 1'b1, p_csb = 1'b1, p_ldac = 1'b1;
    logic [15:0] sh = '0;
    int          nb = 0, lead = 0, csfall_c = 0, sckfall_c = 0, ldfall_c = 0;
    logic [15:0] fr_word [64];
    int          fr_cs [64], fr_bits [64], fr_lead [64], fr_trail [64];
    int          nfr = 0, nldac = 0, ld_width = 0, ld_rise_c = 0;
    int          ndone = 0, done_c = 0, err_both = 0, err_idle_sck = 0, err_ld_cs = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!cs_a_n && !cs_b_n) err_both = err_both + 1;
        if (sck && cs_a_n && cs_b_n) err_idle_sck = err_idle_sck + 1;
        if (!ldac_n && !(cs_a_n && cs_b_n)) err_ld_cs = err_ld_cs + 1;
        if ((p_csa && !cs_a_n) || (p_csb && !cs_b_n)) begin
            sh = '0; nb = 0; csfall_c = cyc;
        end
        if (!p_sck && sck && !(cs_a_n && cs_b_n)) begin
            if (nb == 0) lead = cyc - csfall_c;
            sh = {sh[14:0], sdo};
            nb = nb + 1;
        end
        if (p_sck && !sck) sckfall_c = cyc;
        if ((!p_csa && cs_a_n) || (!p_csb && cs_b_n)) begin
            if (nfr < 64) begin
                fr_word[nfr]  = sh;
                fr_cs[nfr]    = (!p_csa) ? 0 : 1;
                fr_bits[nfr]  = nb;
                fr_lead[nfr]  = lead;
                fr_trail[nfr] = cyc - sckfall_c;
            end
            nfr = nfr + 1;
        end
        if (p_ldac && !ldac_n) ldfall_c = cyc;
        if (!p_ldac && ldac_n) begin
            ld_width = cyc - ldfall_c; ld_rise_c = cyc; nldac = nldac + 1;
        end
        if (done) begin ndone = ndone + 1; done_c = cyc; end
        p_sck = sck; p_csa = cs_a_n; p_csb = cs_b_n; p_ldac = ldac_n;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic ch, input logic [15:0] s);
        return {ch, 1'b0, 1'b1, 1'b1, ~s[15], s[14:4]};
    endfunction

    task automatic set_words(input logic [15:0] a, b, c, d);
        st0 = a; st1 = b; st2 = c; st3 = d;
    endtask

    task automatic pulse_send();
        @(negedge clk); send = 1'b1;
        @(negedge clk); send = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_seq(input int base, input int ld_base,
                             input logic [15:0] a, b, c, d);
        logic [15:0] v [4];
        v[0] = a; v[1] = b; v[2] = c; v[3] = d;
        for (int i = 0; i < 4; i++) begin
            int k = base + i;
            chk(fr_cs[k] == i / 2, "R3 select pairing", fr_cs[k], i / 2);
            chk(fr_word[k] == exp_word(i[0], v[i]), "R3 frame word", fr_word[k],
                exp_word(i[0], v[i]));
            chk(fr_word[k][15:12] == {i[0], 3'b011}, "R4 control bits",
                fr_word[k][15:12], {i[0], 3'b011});
            chk(fr_word[k][11:0] == {~v[i][15], v[i][14:4]}, "R5 code", fr_word[k][11:0],
                {~v[i][15], v[i][14:4]});
            chk(fr_bits[k] == 16, "R2 rising edges per frame", fr_bits[k], 16);
            chk(fr_lead[k] == DIV_HALF, "R6 select lead", fr_lead[k], DIV_HALF);
            chk(fr_trail[k] == DIV_HALF, "R6 select trail", fr_trail[k], DIV_HALF);
        end
        chk(nldac - ld_base >= 1, "R7 load pulse present", nldac - ld_base, 1);
        chk(ld_width == LDAC_CYC, "R7 load width", ld_width, LDAC_CYC);
    endtask

    task automatic run_one(input logic [15:0] a, b, c, d);
        int base = nfr, lb = nldac, db = ndone;
        set_words(a, b, c, d);
        pulse_send();
        chk(busy == 1'b1, "R8 busy after send", busy, 1);
        wait_done();
        chk(nfr - base == 4, "R3 frame count", nfr - base, 4);
        chk(nldac - lb == 1, "R7 one load pulse", nldac - lb, 1);
        chk(ndone - db == 1, "R8 one done clock", ndone - db, 1);
        chk(done_c - ld_rise_c == 1, "R8 done after load release", done_c - ld_rise_c, 1);
        chk(busy == 1'b0, "R8 busy cleared", busy, 0);
        check_seq(base, lb, a, b, c, d);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(cs_a_n == 1'b1, "R1 select A idle", cs_a_n, 1);
        chk(cs_b_n == 1'b1, "R1 select B idle", cs_b_n, 1);
        chk(sck == 1'b0, "R1 sck idle", sck, 0);
        chk(ldac_n == 1'b1, "R1 load idle", ldac_n, 1);
        chk(busy == 1'b0 && done == 1'b0, "R1 handshake idle", {busy, done}, 0);
    endtask

    task automatic t_patterns();
        run_one(16'h1234, 16'hABCD, 16'h5A5A, 16'hC3C3);
        run_one(16'h0FF0, 16'hF00F, 16'h7001, 16'h8FFE);
    endtask

    task automatic t_extremes();
        int base = nfr;
        run_one(16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF);
        chk(fr_word[base][11:0] == 12'd0, "R5 most negative", fr_word[base][11:0], 0);
        chk(fr_word[base+1][11:0] == 12'd4095, "R5 most positive",
            fr_word[base+1][11:0], 4095);
        chk(fr_word[base+2][11:0] == 12'd2048, "R5 zero", fr_word[base+2][11:0], 2048);
        chk(fr_word[base+3][11:0] == 12'd2047, "R5 minus lsb", fr_word[base+3][11:0], 2047);
    endtask

    task automatic t_busy_ignore();
        int base = nfr, lb = nldac, db = ndone;
        set_words(16'h2222, 16'h4444, 16'h6666, 16'h9999);
        pulse_send();
        set_words(16'hEEEE, 16'h1111, 16'hDDDD, 16'h0101);  // R10 late change
        repeat (90) @(negedge clk);
        chk(busy == 1'b1, "R9 still busy", busy, 1);
        send = 1'b1;
        @(negedge clk); send = 1'b0;
        wait_done();
        chk(nfr - base == 4, "R9 no extra frames", nfr - base, 4);
        chk(nldac - lb == 1, "R9 no extra load", nldac - lb, 1);
        chk(ndone - db == 1, "R9 single done", ndone - db, 1);
        check_seq(base, lb, 16'h2222, 16'h4444, 16'h6666, 16'h9999);  // R10
    endtask

    task automatic t_back2back();
        int base = nfr, lb = nldac;
        set_words(16'h3C00, 16'hC400, 16'h0800, 16'hF800);
        pulse_send();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        set_words(16'h6000, 16'hA000, 16'h1F00, 16'hE100);
        send = 1'b1;
        @(negedge clk); send = 1'b0;
        chk(busy == 1'b1, "R11 restart in done clock", busy, 1);
        wait_done();
        chk(nfr - base == 8, "R11 eight frames", nfr - base, 8);
        chk(nldac - lb == 2, "R11 two loads", nldac - lb, 2);
        check_seq(base + 4, lb + 1, 16'h6000, 16'hA000, 16'h1F00, 16'hE100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_patterns();
        t_extremes();
        t_busy_ignore();
        t_back2back();
        chk(err_both == 0, "R6 selects overlap", err_both, 0);
        chk(err_idle_sck == 0, "R2 sck outside frame", err_idle_sck, 0);
        chk(err_ld_cs == 0, "R7 load during frame", err_ld_cs, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule